// File: doc/BRIEF.md
# Memory read bandwidth thermal throttler

This block sits beside a memory controller and decides, cycle by cycle, whether read requests may be issued. It receives a count of read transfers completed in each clock (zero to a few), a single configuration word, and an external thermal-alarm pin. While throttling is not in effect, reads always proceed. While it is in effect, time is cut into short repeating monitoring windows. Each window allows a programmed number of transfers, and once that number has been reached the block output holds reads off until the window ends.

Throttling can be entered in three ways. A software force bit turns it on for as long as the bit is set. The alarm pin turns it on while the pin is high, but only when the source selector picks the pin. When the source selector picks the counter source, a long sampling window totals transfers. If that total goes above a scaled threshold, throttling is held for a programmed number of long windows, and after that the long counter starts again from nothing. Clearing the force bit, or dropping the alarm pin, ends throttling at once and empties the monitoring-window counters.

Configuration word layout, from the most significant bit down: bit 48 force, bits 47:46 source select, bits 45:34 per-window cap, bits 33:27 monitoring-window length, bits 26:21 hold count, bits 20:8 threshold, bits 7:0 long-window length.

Top module: `rd_thermal_throttle`

## Requirements
- R1: After synchronous reset, with an all-zero configuration word, `rd_block` is 0.
- R2: While the force bit (bit 48) is 1, throttling is in effect regardless of source select. When it goes to 0 (with no other source active), `rd_block` is 0 in the next sample, and the monitoring counters are cleared, so a fresh window starts from a count of zero when throttling resumes.
- R3: With source select 01, throttling is in effect while `alarm_in` is 1. When `alarm_in` falls, throttling stops and the monitoring counters are cleared.
- R4: With source select 00 or 11, and the force bit at 0, `rd_block` stays 0 for any `alarm_in` and any transfer pattern. The alarm pin has no effect unless source select is 01.
- R5: While throttling is in effect, a monitoring window counts transfers from zero. `rd_block` is 1 from the cycle after the count first becomes greater than or equal to the cap (bits 45:34) until the first cycle of the next window. A cap of 0 blocks reads for the whole of each window.
- R6: The monitoring window is the 7-bit field (bits 33:27) times 16 clocks long. A field of 0 disables enforcement, so `rd_block` stays 0.
- R7: With source select 10, a long window totals transfers. When the total in one long window exceeds the threshold field (bits 20:8) times 2^TSHIFT, throttling lasts for the hold count (bits 26:21) of long windows. After that, sampling restarts with a total of zero.
- R8: The long window is the 8-bit field (bits 7:0) times SCALE clocks. A long-window field of 0, or a hold count of 0, never starts counter-triggered throttling.
- R9: A transfer count of several per clock that steps from below the cap to above it blocks reads, exactly as landing on the cap does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 49 | Configuration word (layout above) |
| alarm_in | input | 1 | External thermal alarm |
| xfer_cnt | input | XFER_W | Read transfers completed this clock |
| rd_block | output | 1 | 1 = hold off read requests |

## Verification
A monitoring-window counter that is wrong shows up as `rd_block` rising too early or too late within a window. It can also show up as `rd_block` failing to drop at the window boundary, which is visible no more than one window length (at most 2032 clocks) after the error. A long-window total or hold counter that has gone astray shows up as throttling that starts at the wrong transfer, or that ends at the wrong long-window boundary. With a small scaling parameter, that is seen within a few tens of clocks. Counters left uncleared when a source drops show up on the first window after throttling resumes, as blocking before the cap has been reached.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    localparam int CFG_W = 49;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'b00,
        SRC_ALARM = 2'b01,
        SRC_COUNT = 2'b10,
        SRC_RSVD  = 2'b11
    } src_e;

    typedef struct packed {
        logic        force_on;
        src_e        src;
        logic [11:0] cap;
        logic [6:0]  mwin;
        logic [5:0]  hold;
        logic [12:0] thr;
        logic [7:0]  lwin;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        return cfg_t'(w);
    endfunction

    function automatic logic [10:0] mwin_clocks(input logic [6:0] f);
        return {f, 4'b0000};
    endfunction

endpackage

// File: rtl/rtt_long_monitor.sv
module rtt_long_monitor #(
    parameter int XFER_W = 3,
    parameter int SCALE  = 400000,
    parameter int TSHIFT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctr_en,
    input  logic [7:0]        lwin,
    input  logic [12:0]       thr,
    input  logic [5:0]        hold,
    input  logic [XFER_W-1:0] xfer,
    output logic              holding
);
    localparam int LCNT_W = $clog2(255 * SCALE + 1);
    localparam int SUM_W  = 13 + TSHIFT + 1;

    logic [LCNT_W-1:0] len, pos_q;
    logic [SUM_W-1:0]  thr_full, sum_q, sum_nx;
    logic [5:0]        hcnt_q;
    logic              hold_q;
    logic              at_end;

    assign len      = LCNT_W'(lwin) * LCNT_W'(SCALE);
    assign thr_full = SUM_W'(thr) << TSHIFT;
    assign sum_nx   = sum_q + SUM_W'(xfer);
    assign at_end   = (len != '0) && (pos_q == len - 1'b1);
    assign holding  = hold_q;

    always_ff @(posedge clk) begin
        if (rst || !ctr_en) begin
            pos_q  <= '0;
            sum_q  <= '0;
            hcnt_q <= '0;
            hold_q <= 1'b0;
        end else if (hold_q) begin
            if (len == '0) begin
                hold_q <= 1'b0;
                pos_q  <= '0;
                hcnt_q <= '0;
            end else if (at_end) begin
                pos_q <= '0;
                if (hcnt_q + 6'd1 >= hold) begin
                    hold_q <= 1'b0;
                    hcnt_q <= '0;
                    sum_q  <= '0;
                end else begin
                    hcnt_q <= hcnt_q + 6'd1;
                end
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end else if (len != '0) begin
            if (sum_nx > thr_full && hold != '0) begin
                hold_q <= 1'b1;
                pos_q  <= '0;
                sum_q  <= '0;
                hcnt_q <= '0;
            end else if (at_end) begin
                pos_q <= '0;
                sum_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
                sum_q <= (sum_nx > thr_full) ? thr_full + 1'b1 : sum_nx;
            end
        end
    end

    assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        !ctr_en |=> !hold_q);

    assert_trigger_needs_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ctr_en && !hold_q && hold == '0) |=> !hold_q);

    assert_fresh_after_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (hold_q && ctr_en) |=> (hold_q || sum_q == '0));

endmodule

// File: rtl/rtt_window_limiter.sv
module rtt_window_limiter #(
    parameter int XFER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [6:0]        mwin,
    input  logic [11:0]       cap,
    input  logic [XFER_W-1:0] xfer,
    output logic              block
);
    import rtt_pkg::*;

    localparam int CNT_W = ((XFER_W > 12) ? XFER_W : 12) + 1;

    logic [10:0]      win_len, pos_q;
    logic [CNT_W-1:0] cnt_q, cnt_nx, cap_w;
    logic             enforce, at_end, reached;

    assign win_len = mwin_clocks(mwin);
    assign enforce = active && (win_len != '0);
    assign at_end  = (pos_q == win_len - 11'd1);
    assign cap_w   = CNT_W'(cap);
    assign reached = (cnt_q >= cap_w);
    assign cnt_nx  = cnt_q + CNT_W'(xfer);
    assign block   = enforce && reached;

    always_ff @(posedge clk) begin
        if (rst || !enforce) begin
            pos_q <= '0;
            cnt_q <= '0;
        end else if (at_end) begin
            pos_q <= '0;
            cnt_q <= '0;
        end else begin
            pos_q <= pos_q + 11'd1;
            if (!reached) cnt_q <= cnt_nx;
        end
    end

    assert_clear_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !enforce |=> (cnt_q == '0 && pos_q == '0));

    assert_restart_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        (enforce && at_end) |=> (cnt_q == '0 && pos_q == '0));

    assert_step_past_cap_R9: assert property (@(posedge clk) disable iff (rst)
        (enforce && !at_end && !reached && cnt_nx >= cap_w) ##1 (active && $stable(mwin) && $stable(cap)) |-> block);

endmodule

// File: rtl/rd_thermal_throttle.sv
module rd_thermal_throttle #(
    parameter int XFER_W = 3,
    parameter int SCALE  = 400000,
    parameter int TSHIFT = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [rtt_pkg::CFG_W-1:0]  cfg_word,
    input  logic                       alarm_in,
    input  logic [XFER_W-1:0]          xfer_cnt,
    output logic                       rd_block
);
    import rtt_pkg::*;

    cfg_t cfg;
    logic holding, active, ctr_en, alarm_on;

    assign cfg      = unpack_cfg(cfg_word);
    assign ctr_en   = (cfg.src == SRC_COUNT);
    assign alarm_on = (cfg.src == SRC_ALARM) && alarm_in;
    assign active   = cfg.force_on || alarm_on || (ctr_en && holding);

    rtt_long_monitor #(.XFER_W(XFER_W), .SCALE(SCALE), .TSHIFT(TSHIFT)) u_long (
        .clk(clk), .rst(rst), .ctr_en(ctr_en), .lwin(cfg.lwin), .thr(cfg.thr),
        .hold(cfg.hold), .xfer(xfer_cnt), .holding(holding)
    );

    rtt_window_limiter #(.XFER_W(XFER_W)) u_win (
        .clk(clk), .rst(rst), .active(active), .mwin(cfg.mwin), .cap(cfg.cap),
        .xfer(xfer_cnt), .block(rd_block)
    );

    assert_block_needs_source_R4: assert property (@(posedge clk) disable iff (rst)
        rd_block |-> (cfg.force_on || (cfg.src == SRC_ALARM && alarm_in) || (cfg.src == SRC_COUNT)));

    assert_zero_window_open_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.mwin == '0) |-> !rd_block);

endmodule

// File: tb/rd_thermal_throttle_test.sv
module rd_thermal_throttle_test;
    localparam int XW = 3;
    localparam int SC = 5;
    localparam int TS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [48:0] cfg_word = '0;
    logic alarm_in = 1'b0;
    logic [XW-1:0] xfer_cnt = '0;
    logic rd_block;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rd_thermal_throttle #(.XFER_W(XW), .SCALE(SC), .TSHIFT(TS)) uut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .alarm_in(alarm_in),
        .xfer_cnt(xfer_cnt), .rd_block(rd_block)
    );

    typedef struct packed {
        logic        f;
        logic [1:0]  m;
        logic        al;
        logic [11:0] cap;
        logic [6:0]  mw;
        logic [7:0]  lw;
        logic [12:0] th;
        logic [5:0]  hd;
        logic [2:0]  amt;
        logic [3:0]  per;
        logic [7:0]  cyc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 1'b0, 12'd5, 7'd1, 8'd0, 13'd0, 6'd0, 3'd1, 4'd1, 8'd64, 4'd5},  // R5 cap by single steps
        '{1'b1, 2'd0, 1'b0, 12'd6, 7'd1, 8'd0, 13'd0, 6'd0, 3'd4, 4'd1, 8'd64, 4'd9},  // R9 step of 4 past cap 6
        '{1'b1, 2'd3, 1'b0, 12'd0, 7'd2, 8'd0, 13'd0, 6'd0, 3'd1, 4'd3, 8'd80, 4'd5},  // R5 zero cap
        '{1'b1, 2'd0, 1'b1, 12'd1, 7'd0, 8'd0, 13'd0, 6'd0, 3'd2, 4'd1, 8'd40, 4'd6},  // R6 zero window
        '{1'b0, 2'd0, 1'b1, 12'd1, 7'd1, 8'd4, 13'd0, 6'd3, 3'd2, 4'd1, 8'd60, 4'd4},  // R4 off source
        '{1'b0, 2'd1, 1'b1, 12'd3, 7'd1, 8'd0, 13'd0, 6'd0, 3'd1, 4'd2, 8'd70, 4'd3},  // R3 alarm source
        '{1'b0, 2'd3, 1'b1, 12'd1, 7'd1, 8'd4, 13'd0, 6'd3, 3'd2, 4'd1, 8'd60, 4'd4},  // R4 reserved source
        '{1'b0, 2'd2, 1'b0, 12'd2, 7'd1, 8'd4, 13'd3, 6'd2, 3'd1, 4'd1, 8'd150, 4'd7}, // R7 counter trigger
        '{1'b0, 2'd2, 1'b0, 12'd0, 7'd1, 8'd4, 13'd1, 6'd0, 3'd2, 4'd1, 8'd80, 4'd8},  // R8 zero hold
        '{1'b0, 2'd2, 1'b1, 12'd0, 7'd1, 8'd0, 13'd1, 6'd2, 3'd2, 4'd1, 8'd80, 4'd8}   // R8 zero long window
    };

    // reference model state, built from the requirements
    int mpos, mcnt, lpos, lsum, hcnt;
    bit holding;

    function automatic void model_clear();
        mpos = 0; mcnt = 0; lpos = 0; lsum = 0; hcnt = 0; holding = 1'b0;
    endfunction

    function automatic bit model_active();
        return cfg_word[48] || (cfg_word[47:46] == 2'b01 && alarm_in)
            || (cfg_word[47:46] == 2'b10 && holding);
    endfunction

    function automatic bit model_block();
        int wl = int'(cfg_word[33:27]) * 16;
        return model_active() && wl != 0 && mcnt >= int'(cfg_word[45:34]);
    endfunction

    function automatic void model_update();
        int wl   = int'(cfg_word[33:27]) * 16;
        int cap  = int'(cfg_word[45:34]);
        int ll   = int'(cfg_word[7:0]) * SC;
        int thr  = int'(cfg_word[20:8]) * (1 << TS);
        int hd   = int'(cfg_word[26:21]);
        int x    = int'(xfer_cnt);
        bit act  = model_active();
        if (act && wl != 0) begin
            if (mpos == wl - 1) begin mpos = 0; mcnt = 0; end
            else begin mpos++; if (mcnt < cap) mcnt += x; end
        end else begin mpos = 0; mcnt = 0; end
        if (cfg_word[47:46] != 2'b10) begin
            lpos = 0; lsum = 0; hcnt = 0; holding = 1'b0;
        end else if (holding) begin
            if (ll == 0) begin holding = 1'b0; lpos = 0; hcnt = 0; end
            else if (lpos == ll - 1) begin
                lpos = 0;
                if (hcnt + 1 >= hd) begin holding = 1'b0; hcnt = 0; lsum = 0; end
                else hcnt++;
            end else lpos++;
        end else if (ll != 0) begin
            if (lsum + x > thr && hd != 0) begin
                holding = 1'b1; lpos = 0; lsum = 0; hcnt = 0;
            end else if (lpos == ll - 1) begin lpos = 0; lsum = 0; end
            else begin lpos++; lsum += x; end
        end
    endfunction

    task automatic check(input int req, input bit act, input bit exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: rd_block=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // called after inputs are driven at a falling edge
    task automatic tick(input int req);
        #1;
        check(req, rd_block, model_block());
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [48:0] mk(input vec_t v);
        return {v.f, v.m, v.cap, v.mw, v.hd, v.th, v.lw};
    endfunction

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();
        // R1: reset state with zero configuration
        #1; check(1, rd_block, 1'b0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cfg_word = mk(VECS[i]);
            alarm_in = VECS[i].al;
            for (int c = 0; c < int'(VECS[i].cyc); c++) begin
                xfer_cnt = ((c % int'(VECS[i].per)) == 0) ? VECS[i].amt : '0;
                tick(int'(VECS[i].req));
            end
            xfer_cnt = '0;
            do_reset();
        end

        // R2: force drop clears counters, resume starts at zero
        cfg_word = {1'b1, 2'b00, 12'd2, 7'd2, 6'd0, 13'd0, 8'd0};
        xfer_cnt = 3'd1;
        repeat (3) tick(2);
        #1; check(2, rd_block, 1'b1);
        @(negedge clk);
        cfg_word[48] = 1'b0;
        #1; check(2, rd_block, 1'b0);
        @(posedge clk); model_update(); @(negedge clk);
        cfg_word[48] = 1'b1; xfer_cnt = '0;
        #1; check(2, rd_block, 1'b0);
        @(posedge clk); model_update(); @(negedge clk);
        repeat (4) tick(2);
        do_reset();

        // R3: alarm drop clears counters
        cfg_word = {1'b0, 2'b01, 12'd1, 7'd3, 6'd0, 13'd0, 8'd0};
        alarm_in = 1'b1; xfer_cnt = 3'd2;
        repeat (2) tick(3);
        #1; check(3, rd_block, 1'b1);
        @(negedge clk);
        alarm_in = 1'b0;
        #1; check(3, rd_block, 1'b0);
        @(posedge clk); model_update(); @(negedge clk);
        alarm_in = 1'b1; xfer_cnt = '0;
        #1; check(3, rd_block, 1'b0);
        @(posedge clk); model_update(); @(negedge clk);
        repeat (6) tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule